// File: doc/BRIEF.md
# Density Classification and Back-to-Front Compositor

This block sits at the end of a slice-based volume renderer. Resampled scalar densities arrive one per cycle, each tagged with the index of the screen pixel it lands on. A loadable 256-entry table turns every density into a red, green, blue and opacity quadruple. The block then blends that color over the color already held for the pixel, in place, in a small on-chip frame accumulator. Slices are fed farthest first, so each new sample is the foreground and the stored color is the background it covers.

Before the first slice of a frame, a clear command paints every accumulator pixel with a background color. The table is loaded through a simple write port while no sample is in flight. The finished image is read back one pixel at a time through a registered read port. A sample reaches the accumulator two clock edges after it is accepted. Samples that hit the same pixel back to back are forwarded inside the pipeline, so each one blends over the result of the one before it.

Top module: `dens_composite`

## Requirements
- R1: After reset, `s_ready` is 1 and no sample is in flight.
- R2: A table write made while no sample is in flight stores `lut_rgba` at `lut_addr`. The packing is red in bits 31:24, green in 23:16, blue in 15:8 and opacity in 7:0. A later sample with that density uses the stored entry.
- R3: Each channel of an accepted sample is blended as `(a*fg + (255-a)*bg + 127) / 255`, where a is the table opacity, fg is the table color and bg is the pixel's current color. The result is written back to the pixel. The accumulator word is packed red 23:16, green 15:8, blue 7:0.
- R4: Every blended channel lies between the background and foreground values of that channel, inclusive.
- R5: An opacity of 255 replaces the pixel color with the table color exactly.
- R6: An opacity of 0 leaves the pixel color unchanged.
- R7: Samples to the same pixel are applied in arrival order, even with no idle cycle between them. Each one blends over the result of the previous one.
- R8: A `clr_start` pulse sets every pixel to `clr_color`. Samples already accepted are written first. `s_ready` is 0 from the cycle after the pulse until the last pixel is painted.
- R9: A table write presented while a sample is in flight, or in the cycle a sample is accepted, is ignored.
- R10: `rd_rgb` shows the accumulator word at `rd_pix` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample present |
| s_ready | output | 1 | Sample can be taken |
| s_pix | input | PIX_AW | Target pixel index |
| s_dens | input | 8 | Density value |
| lut_we | input | 1 | Table write strobe |
| lut_addr | input | 8 | Table entry to write |
| lut_rgba | input | 32 | Entry value {R,G,B,A} |
| clr_start | input | 1 | Start painting the background |
| clr_color | input | 24 | Background color {R,G,B} |
| rd_pix | input | PIX_AW | Read-back pixel index |
| rd_rgb | output | 24 | Pixel color, one cycle later |

## Verification
Several properties are checked on every cycle: the blend end points (opacity 0 and 255), the bound of each blended channel by its two inputs, the forwarding of a just-computed result into a following sample for the same pixel, mutual exclusion of sample and clear writes, and `s_ready` held low while painting. Only the bench scenarios can show the rest: the exact rounded blend values across a stream of mixed pixels, the ordering of repeated hits to one pixel, that a whole frame is painted by a clear, that a clear waits for samples in flight, and that a table write made during a sample leaves the entry unchanged.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int CH_W    = 8;
  localparam int DENS_W  = 8;
  localparam int NCH     = 3;
  localparam int SUM_W   = 2 * CH_W;
  localparam int OPAQUE  = (1 << CH_W) - 1;
  localparam int RGBA_W  = (NCH + 1) * CH_W;
  localparam int RGB_W   = NCH * CH_W;
  localparam int LUT_N   = 1 << DENS_W;

  // weighted sum of foreground and background for one channel
  function automatic logic [SUM_W-1:0] mix_sum(input logic [CH_W-1:0] a,
                                               input logic [CH_W-1:0] fg,
                                               input logic [CH_W-1:0] bg);
    logic [SUM_W-1:0] pf, pb;
    logic [CH_W-1:0]  inv;
    inv = CH_W'(OPAQUE) - a;
    pf  = SUM_W'(a) * SUM_W'(fg);
    pb  = SUM_W'(inv) * SUM_W'(bg);
    return pf + pb;
  endfunction

  // divide the weighted sum by full scale with round to nearest
  function automatic logic [CH_W-1:0] mix_round(input logic [SUM_W-1:0] s);
    logic [SUM_W:0] t;
    t = {1'b0, s} + (SUM_W+1)'(OPAQUE / 2);
    return CH_W'(t / (SUM_W+1)'(OPAQUE));
  endfunction
endpackage

// File: rtl/dc_lut.sv
module dc_lut
  import dc_pkg::*;
(
  input  logic              clk,
  input  logic              we,
  input  logic [DENS_W-1:0] waddr,
  input  logic [RGBA_W-1:0] wdata,
  input  logic [DENS_W-1:0] raddr,
  output logic [RGBA_W-1:0] rdata
);
  logic [RGBA_W-1:0] tbl [LUT_N];

  always_ff @(posedge clk) begin
    if (we) tbl[waddr] <= wdata;
    rdata <= tbl[raddr];
  end
endmodule

// File: rtl/dc_accum.sv
module dc_accum
  import dc_pkg::*;
#(
  parameter int NPIX   = 1024,
  parameter int PIX_AW = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PIX_AW-1:0] waddr,
  input  logic [RGB_W-1:0]  wdata,
  input  logic [PIX_AW-1:0] addr_a,
  output logic [RGB_W-1:0]  q_a,
  input  logic [PIX_AW-1:0] addr_b,
  output logic [RGB_W-1:0]  q_b
);
  logic [RGB_W-1:0] mem [NPIX];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q_a <= mem[addr_a];
    q_b <= mem[addr_b];
  end
endmodule

// File: rtl/dc_blend.sv
module dc_blend
  import dc_pkg::*;
(
  input  logic [CH_W-1:0]      alpha,
  input  logic [RGB_W-1:0]     fg,
  input  logic [RGB_W-1:0]     bg,
  output logic [NCH*SUM_W-1:0] sum
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sum[c*SUM_W +: SUM_W] = mix_sum(alpha, fg[c*CH_W +: CH_W], bg[c*CH_W +: CH_W]);
  end
endmodule

// File: rtl/dens_composite.sv
module dens_composite
  import dc_pkg::*;
#(
  parameter int IMG_W  = 32,
  parameter int IMG_H  = 32,
  parameter int PIX_AW = $clog2(IMG_W * IMG_H)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [PIX_AW-1:0] s_pix,
  input  logic [DENS_W-1:0] s_dens,
  input  logic              lut_we,
  input  logic [DENS_W-1:0] lut_addr,
  input  logic [RGBA_W-1:0] lut_rgba,
  input  logic              clr_start,
  input  logic [RGB_W-1:0]  clr_color,
  input  logic [PIX_AW-1:0] rd_pix,
  output logic [RGB_W-1:0]  rd_rgb
);
  localparam int NPIX = IMG_W * IMG_H;
  localparam logic [PIX_AW-1:0] LAST_PIX = PIX_AW'(NPIX - 1);

  // ---------------- control ----------------
  logic              accept;
  logic              clr_pend, clr_active;
  logic [PIX_AW-1:0] clr_cnt;
  logic [RGB_W-1:0]  clr_col_q;
  logic              lut_ok;

  // stage 1: table and accumulator reads in flight
  logic              v1;
  logic [PIX_AW-1:0] pix1;
  logic [RGBA_W-1:0] rgba1;
  logic [RGB_W-1:0]  bg_mem;
  logic              hit0;
  logic [RGB_W-1:0]  res_hold;
  logic [RGB_W-1:0]  bg_base, bg_eff;
  logic              fwd_hit;
  logic [NCH*SUM_W-1:0] sum1;

  // stage 2: weighted sums, rounding and write-back
  logic              v2;
  logic [PIX_AW-1:0] pix2;
  logic [NCH*SUM_W-1:0] sum2;
  logic [CH_W-1:0]   a2;
  logic [RGB_W-1:0]  fg2, bg2;
  logic [RGB_W-1:0]  res2;

  // accumulator write port
  logic              smp_we, clr_we, mem_we;
  logic [PIX_AW-1:0] mem_waddr;
  logic [RGB_W-1:0]  mem_wdata;

  assign s_ready = !clr_pend && !clr_active;
  assign accept  = s_valid && s_ready;
  assign lut_ok  = lut_we && !v1 && !v2 && !accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_pend   <= 1'b0;
      clr_active <= 1'b0;
      clr_cnt    <= '0;
      clr_col_q  <= '0;
    end else begin
      if (clr_start && !clr_pend && !clr_active) begin
        clr_pend  <= 1'b1;
        clr_col_q <= clr_color;
      end
      if (clr_pend && !v1 && !v2) begin
        clr_pend   <= 1'b0;
        clr_active <= 1'b1;
        clr_cnt    <= '0;
      end
      if (clr_active) begin
        clr_cnt <= clr_cnt + 1'b1;
        if (clr_cnt == LAST_PIX) clr_active <= 1'b0;
      end
    end
  end

  dc_lut u_lut (
    .clk   (clk),
    .we    (lut_ok),
    .waddr (lut_addr),
    .wdata (lut_rgba),
    .raddr (s_dens),
    .rdata (rgba1)
  );

  dc_accum #(.NPIX(NPIX), .PIX_AW(PIX_AW)) u_accum (
    .clk    (clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  (mem_wdata),
    .addr_a (rd_pix),
    .q_a    (rd_rgb),
    .addr_b (s_pix),
    .q_b    (bg_mem)
  );

  // stage 1 registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1   <= 1'b0;
      hit0 <= 1'b0;
    end else begin
      v1   <= accept;
      hit0 <= v2 && (pix2 == s_pix);
    end
    res_hold <= res2;
    if (accept) pix1 <= s_pix;
  end

  // the memory read misses a write landing on the same edge; the older
  // sample still in stage 2 is one more pixel update ahead of memory
  assign bg_base = hit0 ? res_hold : bg_mem;
  assign fwd_hit = v1 && v2 && (pix1 == pix2);
  assign bg_eff  = fwd_hit ? res2 : bg_base;

  dc_blend u_blend (
    .alpha (rgba1[CH_W-1:0]),
    .fg    (rgba1[RGBA_W-1:CH_W]),
    .bg    (bg_eff),
    .sum   (sum1)
  );

  // stage 2 registers
  always_ff @(posedge clk) begin
    if (!rst_n) v2 <= 1'b0;
    else        v2 <= v1;
    pix2 <= pix1;
    sum2 <= sum1;
    a2   <= rgba1[CH_W-1:0];
    fg2  <= rgba1[RGBA_W-1:CH_W];
    bg2  <= bg_eff;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_rnd
    assign res2[c*CH_W +: CH_W] = mix_round(sum2[c*SUM_W +: SUM_W]);
  end

  assign smp_we    = v2;
  assign clr_we    = clr_active;
  assign mem_we    = smp_we || clr_we;
  assign mem_waddr = clr_we ? clr_cnt : pix2;
  assign mem_wdata = clr_we ? clr_col_q : res2;
endmodule

// File: rtl/dc_checker.sv
module dc_checker
  import dc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             s_ready,
  input logic             clr_active,
  input logic             smp_we,
  input logic             clr_we,
  input logic             fwd_hit,
  input logic [CH_W-1:0]  a2,
  input logic [RGB_W-1:0] fg2,
  input logic [RGB_W-1:0] bg2,
  input logic [RGB_W-1:0] wdata
);
  // R5: full opacity copies the table color
  a_r5_opaque_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_we && a2 == CH_W'(OPAQUE)) |-> (wdata == fg2));

  // R6: zero opacity keeps the background
  a_r6_clear_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_we && a2 == '0) |-> (wdata == bg2));

  // R7: a forwarded result becomes the next sample's background
  a_r7_forward_used: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_hit |=> (bg2 == $past(wdata)));

  // R8: painting and sample write-back never share the write port
  a_r8_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_we && clr_we));

  // R8: no sample accepted while painting
  a_r8_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    clr_active |-> !s_ready);

  // R4: each channel bounded by its two inputs
  for (genvar c = 0; c < NCH; c++) begin : g_bnd
    a_r4_between: assert property (@(posedge clk) disable iff (!rst_n)
      smp_we |->
        ((wdata[c*CH_W +: CH_W] >= fg2[c*CH_W +: CH_W] && wdata[c*CH_W +: CH_W] <= bg2[c*CH_W +: CH_W]) ||
         (wdata[c*CH_W +: CH_W] <= fg2[c*CH_W +: CH_W] && wdata[c*CH_W +: CH_W] >= bg2[c*CH_W +: CH_W])));
  end
endmodule

bind dens_composite dc_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .s_ready    (s_ready),
  .clr_active (clr_active),
  .smp_we     (smp_we),
  .clr_we     (clr_we),
  .fwd_hit    (fwd_hit),
  .a2         (a2),
  .fg2        (fg2),
  .bg2        (bg2),
  .wdata      (res2)
);

// File: tb/dens_composite_tb_top.sv
module dens_composite_tb_top;
  localparam int NPIX = 1024;
  localparam int AW   = 10;
  localparam int NVEC = 16;

  // stimulus vectors {pixel, density}; expected colors come from the model
  localparam logic [17:0] VEC [NVEC] = '{
    {10'd5, 8'd200}, {10'd5, 8'd100}, {10'd5, 8'd60},  {10'd9, 8'd128},
    {10'd9, 8'd255}, {10'd9, 8'd30},  {10'd1023, 8'd77}, {10'd0, 8'd1},
    {10'd0, 8'd254}, {10'd300, 8'd128}, {10'd5, 8'd0},  {10'd5, 8'd180},
    {10'd12, 8'd90}, {10'd9, 8'd90},  {10'd12, 8'd90}, {10'd1023, 8'd255}
  };

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, s_ready;
  logic [AW-1:0] s_pix = 0;
  logic [7:0] s_dens = 0;
  logic lut_we = 0;
  logic [7:0] lut_addr = 0;
  logic [31:0] lut_rgba = 0;
  logic clr_start = 0;
  logic [23:0] clr_color = 0;
  logic [AW-1:0] rd_pix = 0;
  logic [23:0] rd_rgb;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  logic [31:0] lut_m [256];
  logic [23:0] img_m [NPIX];

  always #10 clk = ~clk;

  dens_composite dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_pix(s_pix), .s_dens(s_dens), .lut_we(lut_we), .lut_addr(lut_addr),
    .lut_rgba(lut_rgba), .clr_start(clr_start), .clr_color(clr_color),
    .rd_pix(rd_pix), .rd_rgb(rd_rgb)
  );

  // model: round(x/255) written as floor((2x+255)/510)
  function automatic logic [7:0] ref_ch(input int a, input int f, input int b);
    int num;
    num = a * f + (255 - a) * b;
    return 8'((2 * num + 255) / 510);
  endfunction

  function automatic logic [23:0] ref_pix(input logic [31:0] e, input logic [23:0] bg);
    int a;
    a = int'(e[7:0]);
    return {ref_ch(a, int'(e[31:24]), int'(bg[23:16])),
            ref_ch(a, int'(e[23:16]), int'(bg[15:8])),
            ref_ch(a, int'(e[15:8]),  int'(bg[7:0]))};
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_pix(input logic [AW-1:0] p, output logic [23:0] v);
    @(negedge clk) rd_pix = p;
    @(posedge clk);
    @(negedge clk) v = rd_rgb;
  endtask

  task automatic lut_write(input logic [7:0] ad, input logic [31:0] d);
    @(negedge clk);
    lut_we = 1; lut_addr = ad; lut_rgba = d;
    @(posedge clk);
    @(negedge clk) lut_we = 0;
  endtask

  task automatic send(input logic [AW-1:0] p, input logic [7:0] d);
    @(negedge clk);
    s_valid = 1; s_pix = p; s_dens = d;
    img_m[p] = ref_pix(lut_m[d], img_m[p]);
    @(posedge clk);
    @(negedge clk) s_valid = 0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (s_ready) break;
    end
  endtask

  task automatic paint(input logic [23:0] col);
    @(negedge clk);
    clr_start = 1; clr_color = col;
    @(posedge clk);
    @(negedge clk) clr_start = 0;
    for (int p = 0; p < NPIX; p++) img_m[p] = col;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [23:0] v;
    logic [31:0] old_e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: ready after reset
    @(negedge clk) check("R1 ready", {23'd0, s_ready}, 24'd1);

    // R2: load table at idle
    for (int d = 0; d < 256; d++) begin
      lut_m[d] = {8'(d), 8'(255 - d), 8'(d) ^ 8'h5a, 8'(d)};
      lut_write(8'(d), lut_m[d]);
    end

    // R8: paint the frame
    paint(24'h102030);
    check("R8 ready low", {23'd0, s_ready}, 24'd0);
    wait_ready();
    read_pix(10'd0, v);    check("R8 pix0", v, 24'h102030);
    read_pix(10'd1023, v); check("R8 pix1023", v, 24'h102030);
    read_pix(10'd500, v);  check("R10 pix500", v, 24'h102030);

    // R3/R7: streamed vectors, back-to-back hits on one pixel
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      s_valid = 1; s_pix = VEC[i][17:8]; s_dens = VEC[i][7:0];
      img_m[VEC[i][17:8]] = ref_pix(lut_m[VEC[i][7:0]], img_m[VEC[i][17:8]]);
      @(posedge clk);
    end
    @(negedge clk) s_valid = 0;
    repeat (4) @(posedge clk);
    for (int i = 0; i < NVEC; i++) begin
      read_pix(VEC[i][17:8], v);
      check("R3/R7 stream", v, img_m[VEC[i][17:8]]);
    end

    // R6: opacity 0 leaves pixel
    send(10'd300, 8'd0);
    repeat (4) @(posedge clk);
    read_pix(10'd300, v); check("R6 alpha0", v, img_m[300]);
    // R5: opacity 255 replaces
    send(10'd301, 8'd255);
    repeat (4) @(posedge clk);
    read_pix(10'd301, v); check("R5 alpha255", v, {8'd255, 8'd0, 8'ha5});

    // R4: mid opacity bounded by both inputs
    send(10'd40, 8'd128);
    repeat (4) @(posedge clk);
    read_pix(10'd40, v);
    check("R4 exact", v, img_m[40]);
    vectors++;
    if (!(v[23:16] >= 8'h10 && v[23:16] <= 8'd128 && v[15:8] >= 8'h20 && v[15:8] <= 8'd127 &&
          v[7:0] >= 8'h30 && v[7:0] <= 8'hda)) begin
      miscompares++;
      $display("FAIL R4 bound: got %h expected within bg 102030 / fg 807fda", v);
    end

    // R9: table write during an in-flight sample is dropped
    old_e = lut_m[50];
    @(negedge clk);
    s_valid = 1; s_pix = 10'd20; s_dens = 8'd40;
    img_m[20] = ref_pix(lut_m[40], img_m[20]);
    @(posedge clk);
    @(negedge clk);
    s_valid = 0; lut_we = 1; lut_addr = 8'd50; lut_rgba = 32'hFFFFFFFF;
    @(posedge clk);
    @(negedge clk) lut_we = 0;
    repeat (3) @(posedge clk);
    send(10'd21, 8'd50);
    repeat (4) @(posedge clk);
    read_pix(10'd21, v); check("R9 ignored", v, ref_pix(old_e, 24'h102030));

    // R2: idle write takes effect
    lut_m[51] = 32'h11EE7780;
    lut_write(8'd51, lut_m[51]);
    send(10'd22, 8'd51);
    repeat (4) @(posedge clk);
    read_pix(10'd22, v); check("R2 new entry", v, img_m[22]);

    // R8: clear issued right behind a sample
    @(negedge clk);
    s_valid = 1; s_pix = 10'd30; s_dens = 8'd200;
    @(posedge clk);
    @(negedge clk);
    s_valid = 0; clr_start = 1; clr_color = 24'hA0B0C0;
    @(posedge clk);
    @(negedge clk) clr_start = 0;
    check("R8 ready low2", {23'd0, s_ready}, 24'd0);
    wait_ready();
    read_pix(10'd30, v); check("R8 after sample", v, 24'hA0B0C0);
    read_pix(10'd777, v); check("R8 full frame", v, 24'hA0B0C0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule